// File: doc/BRIEF.md
# Mezzanine Carrier Address Decoder

This block sits behind the VMEbus slave interface of a carrier board that hosts four mezzanine I/O module slots, numbered 0 to 3. It watches the address, address modifier, address strobe and write line of each bus cycle. When a cycle targets one of the slots, it raises a select strobe that names the slot and the space. The spaces are a short-address I/O window, a short-address ID window and a memory window. The block also presents the slot-relative offset. The data path, the handshake toward the modules and the acknowledge generation belong to other blocks. This block only reports a match and its kind.

Short-address (A16) accesses reach a 128-byte I/O window and a 128-byte ID window per slot. These windows are packed into one 1 KB region. Memory accesses use one mode for the whole board. In standard mode (A24), every slot has a 2 MB region with a window size chosen per slot. In extended mode (A32), every slot has a fixed 8 MB window. The decode is captured at the start of each cycle and held while the address strobe stays low. This is what lets a read-modify-write semaphore cycle complete on I/O space. Each slot also has an activity output, stretched long enough to drive a front-panel lamp.

Top module: `mezz_carrier_decoder`

## Requirements
- R1: With AM 0x29 (user) or 0x2D (supervisor), and addr[15:10] equal to `cfg_short_base`, and addr[7]=0, the block asserts `io_sel[addr[9:8]]`. It drives `slot_offset` with addr[6:0] and zeros above. Reads and writes are both accepted.
- R2: With the same AM and base check, and addr[7]=1, a read (`write_n`=1) asserts `id_sel[addr[9:8]]`, with `slot_offset` = addr[6:0].
- R3: A write to an ID window never asserts any select and does not trigger activity. This includes the write phase of a read-modify-write cycle.
- R4: In standard mode (`cfg_ext_mode`=0), AM 0x39, 0x3A, 0x3D or 0x3E with addr[23] equal to `cfg_std_base` selects slot addr[22:21]. The offset is addr[20:0]. Size codes 1..5 give windows of 128 KB, 256 KB, 512 KB, 1 MB and 2 MB. An offset at or above the window size gives no select.
- R5: In standard mode, a slot whose size code is 0, 6 or 7 never asserts its memory select.
- R6: In extended mode (`cfg_ext_mode`=1), AM 0x09, 0x0A, 0x0D or 0x0E with addr[31:25] equal to `cfg_ext_base` selects slot addr[24:23]. The window is a fixed 8 MB, with offset addr[22:0], and the size codes are ignored.
- R7: The mode applies to the whole board. Extended AMs give no select in standard mode, and standard AMs give no select in extended mode.
- R8: The decode is captured at the first rising clock edge that samples `as_n` low. Selects and offset are valid after that edge. An address change later in the same cycle has no effect. All selects drop as soon as `as_n` is high.
- R9: While `as_n` stays low, an I/O select stays asserted when `write_n` changes. This supports read-modify-write cycles.
- R10: A cycle start that produces a select loads that slot's activity output. The output then stays high for exactly 2^`STRETCH_LOG2` clock cycles after the start edge. A new access to the slot restarts the count.
- R11: Accesses with any other AM, or with a base that does not match, produce no select and no activity.
- R12: After synchronous reset, all selects, `slot_offset` and all activity outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all bus inputs are synchronous to it |
| rst | input | 1 | Synchronous active-high reset |
| vme_addr | input | 32 | Bus address |
| vme_am | input | 6 | Address modifier |
| as_n | input | 1 | Address strobe, active low |
| write_n | input | 1 | Low for a write cycle |
| cfg_short_base | input | 6 | Address bits 15:10 of the short I/O and ID region |
| cfg_std_base | input | 1 | Address bit 23 of the standard memory region |
| cfg_ext_base | input | 7 | Address bits 31:25 of the extended memory region |
| cfg_ext_mode | input | 1 | 1 selects extended (A32) memory for all slots |
| cfg_size_code | input | 12 | Three bits per slot, slot n at bits 3n+2:3n, window size code |
| io_sel | output | 4 | Per-slot I/O space select |
| id_sel | output | 4 | Per-slot ID space select |
| mem_sel | output | 4 | Per-slot memory space select |
| slot_offset | output | 23 | Slot-relative byte offset of the captured address |
| activity | output | 4 | Per-slot stretched access indicator |

## Verification
The bench builds the decoder with `STRETCH_LOG2` = 4, so each activity output holds for 16 cycles. This makes the exact drop edge and a restart of the count reachable in a few dozen cycles. All other values come from the package and stay at their defaults. Those defaults cover the window-size edges at 128 KB, 512 KB and 2 MB, the full 8 MB extended window, and the short-address slot packing.

// File: rtl/mezz_dec_pkg.sv
package mezz_dec_pkg;

    localparam int NSLOT      = 4;
    localparam int SLOT_W     = $clog2(NSLOT);
    localparam int SHORT_W    = 7;                 // 128-byte windows
    localparam int STD_REG_W  = 21;                // 2 MB per slot region
    localparam int EXT_REG_W  = 23;                // 8 MB per slot region
    localparam int OFS_W      = EXT_REG_W;
    localparam int CODE_W     = 3;
    localparam int SHORT_BASE_W = 16 - (SHORT_W + 1 + SLOT_W);
    localparam int STD_BASE_W   = 24 - (STD_REG_W + SLOT_W);
    localparam int EXT_BASE_W   = 32 - (EXT_REG_W + SLOT_W);
    localparam int MIN_WIN_LOG2 = 17;              // 128 KB for code 1

    localparam logic [5:0] AM_SHORT_USR = 6'h29;
    localparam logic [5:0] AM_SHORT_SUP = 6'h2D;

    typedef enum logic [1:0] {
        SP_NONE = 2'd0,
        SP_IO   = 2'd1,
        SP_ID   = 2'd2,
        SP_MEM  = 2'd3
    } space_e;

    typedef struct packed {
        space_e              space;
        logic [SLOT_W-1:0]   slot;
        logic [OFS_W-1:0]    ofs;
    } decode_t;

    function automatic logic am_is_short(input logic [5:0] am);
        return (am == AM_SHORT_USR) || (am == AM_SHORT_SUP);
    endfunction

    // data or program access, user or supervisor
    function automatic logic am_is_std(input logic [5:0] am);
        return (am[5:3] == 3'b111) && (am[1:0] != 2'b00) && (am[1:0] != 2'b11);
    endfunction

    function automatic logic am_is_ext(input logic [5:0] am);
        return (am[5:3] == 3'b001) && (am[1:0] != 2'b00) && (am[1:0] != 2'b11);
    endfunction

    // window length in bytes; zero for disabled codes
    function automatic logic [STD_REG_W:0] std_win_len(input logic [CODE_W-1:0] code);
        logic [STD_REG_W:0] len;
        len = '0;
        if (code >= 3'd1 && code <= 3'd5)
            len = ({{STD_REG_W{1'b0}}, 1'b1} << (MIN_WIN_LOG2 - 1 + int'(code)));
        return len;
    endfunction

endpackage

// File: rtl/mezz_short_decode.sv
module mezz_short_decode
    import mezz_dec_pkg::*;
(
    input  logic [15:0]             addr,
    input  logic [5:0]              am,
    input  logic [SHORT_BASE_W-1:0] base,
    output logic                    hit,
    output logic                    is_id,
    output logic [SLOT_W-1:0]       slot,
    output logic [SHORT_W-1:0]      ofs
);

    localparam int SLOT_LO = SHORT_W + 1;

    always_comb begin
        hit   = am_is_short(am) && (addr[15 -: SHORT_BASE_W] == base);
        is_id = addr[SHORT_W];
        slot  = addr[SLOT_LO +: SLOT_W];
        ofs   = addr[SHORT_W-1:0];
    end

endmodule

// File: rtl/mezz_memwin_decode.sv
module mezz_memwin_decode
    import mezz_dec_pkg::*;
(
    input  logic [31:0]               addr,
    input  logic [5:0]                am,
    input  logic                      ext_mode,
    input  logic [STD_BASE_W-1:0]     std_base,
    input  logic [EXT_BASE_W-1:0]     ext_base,
    input  logic [NSLOT*CODE_W-1:0]   size_code,
    output logic                      hit,
    output logic [SLOT_W-1:0]         slot,
    output logic [OFS_W-1:0]          ofs
);

    logic [SLOT_W-1:0]     std_slot;
    logic [STD_REG_W-1:0]  std_ofs;
    logic [CODE_W-1:0]     std_code;
    logic                  std_hit;
    logic                  ext_hit;

    always_comb begin
        std_slot = addr[STD_REG_W +: SLOT_W];
        std_ofs  = addr[STD_REG_W-1:0];
        std_code = size_code[std_slot*CODE_W +: CODE_W];
        std_hit  = !ext_mode && am_is_std(am)
                && (addr[23 -: STD_BASE_W] == std_base)
                && ({1'b0, std_ofs} < std_win_len(std_code));
        ext_hit  = ext_mode && am_is_ext(am)
                && (addr[31 -: EXT_BASE_W] == ext_base);
        hit  = std_hit || ext_hit;
        if (ext_mode) begin
            slot = addr[EXT_REG_W +: SLOT_W];
            ofs  = addr[EXT_REG_W-1:0];
        end else begin
            slot = std_slot;
            ofs  = {{(OFS_W-STD_REG_W){1'b0}}, std_ofs};
        end
    end

endmodule

// File: rtl/mezz_activity_stretch.sv
module mezz_activity_stretch #(
    parameter int STRETCH_LOG2 = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    output logic active
);

    localparam int CNT_W = STRETCH_LOG2 + 1;
    localparam logic [CNT_W-1:0] LOAD = {1'b1, {STRETCH_LOG2{1'b0}}};

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (trig)
            cnt_q <= LOAD;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign active = (cnt_q != '0);

    // R10: a trigger lights the indicator on the next cycle
    p_load_r10: assert property (@(posedge clk) disable iff (rst)
        trig |=> active);

    // R10: indicator only goes dark once the count has run out
    p_drop_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(active) |-> ($past(cnt_q) == {{(CNT_W-1){1'b0}}, 1'b1}));

endmodule

// File: rtl/mezz_carrier_decoder.sv
module mezz_carrier_decoder
    import mezz_dec_pkg::*;
#(
    parameter int STRETCH_LOG2 = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [31:0]                 vme_addr,
    input  logic [5:0]                  vme_am,
    input  logic                        as_n,
    input  logic                        write_n,
    input  logic [SHORT_BASE_W-1:0]     cfg_short_base,
    input  logic [STD_BASE_W-1:0]       cfg_std_base,
    input  logic [EXT_BASE_W-1:0]       cfg_ext_base,
    input  logic                        cfg_ext_mode,
    input  logic [NSLOT*CODE_W-1:0]     cfg_size_code,
    output logic [NSLOT-1:0]            io_sel,
    output logic [NSLOT-1:0]            id_sel,
    output logic [NSLOT-1:0]            mem_sel,
    output logic [OFS_W-1:0]            slot_offset,
    output logic [NSLOT-1:0]            activity
);

    logic                 s_hit, s_is_id;
    logic [SLOT_W-1:0]    s_slot;
    logic [SHORT_W-1:0]   s_ofs;
    logic                 m_hit;
    logic [SLOT_W-1:0]    m_slot;
    logic [OFS_W-1:0]     m_ofs;

    mezz_short_decode u_short (
        .addr  (vme_addr[15:0]),
        .am    (vme_am),
        .base  (cfg_short_base),
        .hit   (s_hit),
        .is_id (s_is_id),
        .slot  (s_slot),
        .ofs   (s_ofs)
    );

    mezz_memwin_decode u_mem (
        .addr      (vme_addr),
        .am        (vme_am),
        .ext_mode  (cfg_ext_mode),
        .std_base  (cfg_std_base),
        .ext_base  (cfg_ext_base),
        .size_code (cfg_size_code),
        .hit       (m_hit),
        .slot      (m_slot),
        .ofs       (m_ofs)
    );

    decode_t dec_now, dec_q;
    logic    cyc_q;
    logic    start;
    logic    live;
    logic    grant_now;

    always_comb begin
        dec_now = '{space: SP_NONE, slot: '0, ofs: '0};
        if (s_hit) begin
            dec_now.space = s_is_id ? SP_ID : SP_IO;
            dec_now.slot  = s_slot;
            dec_now.ofs   = {{(OFS_W-SHORT_W){1'b0}}, s_ofs};
        end else if (m_hit) begin
            dec_now.space = SP_MEM;
            dec_now.slot  = m_slot;
            dec_now.ofs   = m_ofs;
        end
        start     = !as_n && !cyc_q;
        grant_now = (dec_now.space == SP_IO) || (dec_now.space == SP_MEM)
                 || ((dec_now.space == SP_ID) && write_n);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_q <= 1'b0;
            dec_q <= '{space: SP_NONE, slot: '0, ofs: '0};
        end else if (as_n) begin
            cyc_q <= 1'b0;
        end else if (!cyc_q) begin
            cyc_q <= 1'b1;
            dec_q <= dec_now;
        end
    end

    assign live        = cyc_q && !as_n;
    assign slot_offset = dec_q.ofs;

    for (genvar n = 0; n < NSLOT; n++) begin : g_slot
        logic slot_match;
        assign slot_match = (dec_q.slot == SLOT_W'(n));
        assign io_sel[n]  = live && slot_match && (dec_q.space == SP_IO);
        assign id_sel[n]  = live && slot_match && (dec_q.space == SP_ID) && write_n;
        assign mem_sel[n] = live && slot_match && (dec_q.space == SP_MEM);

        mezz_activity_stretch #(.STRETCH_LOG2(STRETCH_LOG2)) u_act (
            .clk    (clk),
            .rst    (rst),
            .trig   (start && grant_now && (dec_now.slot == SLOT_W'(n))),
            .active (activity[n])
        );

        // R5: disabled standard window never selects
        p_none_r5: assert property (@(posedge clk) disable iff (rst)
            (!cfg_ext_mode && ((cfg_size_code[n*CODE_W +: CODE_W] == 3'd0)
              || (cfg_size_code[n*CODE_W +: CODE_W] > 3'd5))) |-> !mem_sel[n]);
    end

    // R8: at most one select across all slots and spaces
    p_onehot_sel_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({io_sel, id_sel, mem_sel}));

    // R8: idle strobe means no select
    p_idle_r8: assert property (@(posedge clk) disable iff (rst)
        as_n |-> ({io_sel, id_sel, mem_sel} == '0));

    // R3: ID space is never selected on a write
    p_id_rdonly_r3: assert property (@(posedge clk) disable iff (rst)
        (id_sel != '0) |-> write_n);

    // R9: I/O select held while the strobe stays low
    p_rmw_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!as_n && $past(!as_n) && ($past(io_sel) != '0)) |-> (io_sel == $past(io_sel)));

endmodule

// File: tb/test_mezz_carrier_decoder.sv
module test_mezz_carrier_decoder;
    import mezz_dec_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] vme_addr;
    logic [5:0]  vme_am;
    logic        as_n, write_n;
    logic [5:0]  cfg_short_base;
    logic [0:0]  cfg_std_base;
    logic [6:0]  cfg_ext_base;
    logic        cfg_ext_mode;
    logic [11:0] cfg_size_code;
    logic [3:0]  io_sel, id_sel, mem_sel, activity;
    logic [22:0] slot_offset;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2 clk = ~clk;

    mezz_carrier_decoder #(.STRETCH_LOG2(4)) i_mezz_carrier_decoder (
        .clk(clk), .rst(rst), .vme_addr(vme_addr), .vme_am(vme_am),
        .as_n(as_n), .write_n(write_n), .cfg_short_base(cfg_short_base),
        .cfg_std_base(cfg_std_base), .cfg_ext_base(cfg_ext_base),
        .cfg_ext_mode(cfg_ext_mode), .cfg_size_code(cfg_size_code),
        .io_sel(io_sel), .id_sel(id_sel), .mem_sel(mem_sel),
        .slot_offset(slot_offset), .activity(activity)
    );

    localparam logic [31:0] SHORT_BASE_ADDR = 32'h0000_1400;  // base 6'h05
    localparam logic [31:0] STD_BASE_ADDR   = 32'h0080_0000;  // base 1
    localparam logic [31:0] EXT_BASE_ADDR   = 32'h2A00_0000;  // base 7'h15

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic sels_chk(input string req, input logic [3:0] eio,
                            input logic [3:0] eid, input logic [3:0] emem);
        chk(req, {20'd0, io_sel, id_sel, mem_sel}, {20'd0, eio, eid, emem});
    endtask

    // open a cycle: drive on the falling edge, sample after the capture edge
    task automatic open_cyc(input logic [31:0] a, input logic [5:0] am, input logic wr);
        @(negedge clk);
        vme_addr = a; vme_am = am; write_n = !wr; as_n = 1'b0;
        @(posedge clk); #1;
    endtask

    task automatic close_cyc();
        @(negedge clk);
        as_n = 1'b1; write_n = 1'b1;
        @(posedge clk); #1;
    endtask

    function automatic logic [31:0] short_a(input int slot, input bit id, input int ofs);
        return SHORT_BASE_ADDR | (32'(slot) << 8) | (id ? 32'h80 : 32'h0) | 32'(ofs);
    endfunction

    function automatic logic [31:0] std_a(input int slot, input int ofs);
        return STD_BASE_ADDR | (32'(slot) << 21) | 32'(ofs);
    endfunction

    function automatic logic [31:0] ext_a(input int slot, input int ofs);
        return EXT_BASE_ADDR | (32'(slot) << 23) | 32'(ofs);
    endfunction

    task automatic t_reset();
        sels_chk("R12 selects after reset", 4'b0, 4'b0, 4'b0);
        chk("R12 offset after reset", {9'd0, slot_offset}, 32'd0);
        chk("R12 activity after reset", {28'd0, activity}, 32'd0);
    endtask

    task automatic t_io();
        open_cyc(short_a(0, 0, 8'h12), 6'h29, 1'b0);
        sels_chk("R1 user io read slot0", 4'b0001, 4'b0, 4'b0);
        chk("R1 io offset", {9'd0, slot_offset}, 32'h12);
        close_cyc();
        open_cyc(short_a(3, 0, 8'h7E), 6'h2D, 1'b1);
        sels_chk("R1 supervisor io write slot3", 4'b1000, 4'b0, 4'b0);
        chk("R1 io offset slot3", {9'd0, slot_offset}, 32'h7E);
        close_cyc();
    endtask

    task automatic t_id();
        repeat (20) @(posedge clk); #1;
        open_cyc(short_a(2, 1, 5), 6'h29, 1'b0);
        sels_chk("R2 id read slot2", 4'b0, 4'b0100, 4'b0);
        chk("R2 id offset", {9'd0, slot_offset}, 32'h5);
        close_cyc();
        repeat (20) @(posedge clk); #1;
        open_cyc(short_a(1, 1, 5), 6'h2D, 1'b1);
        sels_chk("R3 id write gives no select", 4'b0, 4'b0, 4'b0);
        chk("R3 id write gives no activity", {28'd0, activity}, 32'd0);
        close_cyc();
        open_cyc(short_a(1, 1, 9), 6'h29, 1'b0);
        sels_chk("R3 id rmw read phase", 4'b0, 4'b0010, 4'b0);
        @(negedge clk); write_n = 1'b0; #1;
        sels_chk("R3 id rmw write phase drops", 4'b0, 4'b0, 4'b0);
        close_cyc();
    endtask

    task automatic t_std();
        @(negedge clk);
        cfg_ext_mode  = 1'b0;
        cfg_size_code = {3'd3, 3'd0, 3'd5, 3'd1};   // slot3..slot0
        open_cyc(std_a(0, 32'h1FFFF), 6'h39, 1'b0);
        sels_chk("R4 128K last byte", 4'b0, 4'b0, 4'b0001);
        chk("R4 std offset", {9'd0, slot_offset}, 32'h1FFFF);
        close_cyc();
        open_cyc(std_a(0, 32'h20000), 6'h39, 1'b0);
        sels_chk("R4 128K past end", 4'b0, 4'b0, 4'b0);
        close_cyc();
        open_cyc(std_a(1, 32'h1FFFFF), 6'h3E, 1'b1);
        sels_chk("R4 2M last byte", 4'b0, 4'b0, 4'b0010);
        close_cyc();
        open_cyc(std_a(3, 32'h7FFFF), 6'h3D, 1'b0);
        sels_chk("R4 512K last byte", 4'b0, 4'b0, 4'b1000);
        close_cyc();
        open_cyc(std_a(3, 32'h80000), 6'h3A, 1'b0);
        sels_chk("R4 512K past end", 4'b0, 4'b0, 4'b0);
        close_cyc();
        open_cyc(std_a(2, 0), 6'h39, 1'b0);
        sels_chk("R5 code 0 slot never selects", 4'b0, 4'b0, 4'b0);
        close_cyc();
        @(negedge clk); cfg_size_code[8:6] = 3'd7;
        open_cyc(std_a(2, 0), 6'h39, 1'b0);
        sels_chk("R5 code 7 slot never selects", 4'b0, 4'b0, 4'b0);
        close_cyc();
        open_cyc(ext_a(0, 0), 6'h09, 1'b0);
        sels_chk("R7 ext AM ignored in std mode", 4'b0, 4'b0, 4'b0);
        close_cyc();
        open_cyc(std_a(0, 4) & ~32'h0080_0000, 6'h39, 1'b0);
        sels_chk("R11 std base mismatch", 4'b0, 4'b0, 4'b0);
        close_cyc();
        open_cyc(std_a(0, 4), 6'h3F, 1'b0);
        sels_chk("R11 other AM ignored", 4'b0, 4'b0, 4'b0);
        close_cyc();
        open_cyc(short_a(0, 0, 1) ^ 32'h0400, 6'h2D, 1'b0);
        sels_chk("R11 short base mismatch", 4'b0, 4'b0, 4'b0);
        close_cyc();
    endtask

    task automatic t_ext();
        @(negedge clk);
        cfg_ext_mode  = 1'b1;
        cfg_size_code = 12'd0;
        open_cyc(ext_a(2, 32'h7FFFFF), 6'h0D, 1'b0);
        sels_chk("R6 8M window ignores size code", 4'b0, 4'b0, 4'b0100);
        chk("R6 ext offset", {9'd0, slot_offset}, 32'h7FFFFF);
        close_cyc();
        open_cyc(ext_a(3, 0), 6'h0A, 1'b1);
        sels_chk("R6 ext slot3", 4'b0, 4'b0, 4'b1000);
        close_cyc();
        open_cyc(std_a(1, 0), 6'h39, 1'b0);
        sels_chk("R7 std AM ignored in ext mode", 4'b0, 4'b0, 4'b0);
        close_cyc();
    endtask

    task automatic t_latch();
        open_cyc(short_a(1, 0, 3), 6'h29, 1'b0);
        @(negedge clk); vme_addr = short_a(3, 0, 9);
        @(posedge clk); #1;
        sels_chk("R8 mid-cycle address change ignored", 4'b0010, 4'b0, 4'b0);
        chk("R8 offset held", {9'd0, slot_offset}, 32'h3);
        @(negedge clk); as_n = 1'b1; #1;
        sels_chk("R8 select drops with strobe", 4'b0, 4'b0, 4'b0);
        @(posedge clk); #1;
    endtask

    task automatic t_rmw();
        open_cyc(short_a(2, 0, 4), 6'h2D, 1'b0);
        sels_chk("R9 rmw read phase", 4'b0100, 4'b0, 4'b0);
        @(negedge clk); write_n = 1'b0;
        @(posedge clk); #1;
        sels_chk("R9 rmw write phase held", 4'b0100, 4'b0, 4'b0);
        close_cyc();
    endtask

    task automatic t_act();
        repeat (20) @(posedge clk); #1;
        chk("R10 idle before", {28'd0, activity}, 32'd0);
        open_cyc(short_a(2, 0, 0), 6'h29, 1'b0);      // start edge E0
        chk("R10 set at start", {28'd0, activity}, 32'h4);
        close_cyc();                                  // E1
        repeat (14) @(posedge clk); #1;               // E15
        chk("R10 high at 16th cycle", {31'd0, activity[2]}, 32'd1);
        @(posedge clk); #1;                           // E16
        chk("R10 low after 16 cycles", {31'd0, activity[2]}, 32'd0);
        open_cyc(short_a(0, 0, 0), 6'h29, 1'b0);      // E0
        close_cyc();                                  // E1
        repeat (9) @(posedge clk);                    // E10
        open_cyc(short_a(0, 0, 0), 6'h29, 1'b0);      // E11 restart
        close_cyc();                                  // E12
        repeat (14) @(posedge clk); #1;               // E26
        chk("R10 restart extends", {31'd0, activity[0]}, 32'd1);
        @(posedge clk); #1;                           // E27
        chk("R10 restart ends", {31'd0, activity[0]}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; as_n = 1'b1; write_n = 1'b1;
        vme_addr = '0; vme_am = '0;
        cfg_short_base = 6'h05; cfg_std_base = 1'b1; cfg_ext_base = 7'h15;
        cfg_ext_mode = 1'b0; cfg_size_code = 12'd0;
        repeat (3) @(posedge clk); #1;
        t_reset();
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
        t_io();
        t_id();
        t_std();
        t_ext();
        t_latch();
        t_rmw();
        t_act();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule